// File: doc/BRIEF.md
# Lane Delay Offset Adjuster

This block masters a simple register bus to move the read-strobe delay code of every byte lane of a memory PHY by one signed amount. On a start pulse it captures a lane count and an 8-bit two's-complement step. It then freezes the PHY's voltage/temperature compensation and waits until the PHY reports that compensation has stopped. Next it rewrites each lane's delay register, and finally it lets compensation run again. A typical use is a fixed negative trim of the strobe delays once PHY initialisation has finished.

The bus port is request/acknowledge. The block holds a request with its address, direction and write data steady until a one-cycle acknowledge arrives, and read data is taken in the acknowledge cycle. Every lane is handled as read, modified write, and a dummy read of the same register. The modified write replaces only the delay code field and saturates it, so it never wraps.

Top module: `lane_delay_adjust`

## Requirements
- R1: After start, the block reads the configuration register (address 0x0008), writes it back with bit 26 (compensation inhibit) set and all other bits unchanged, then reads the status register (0x0010) until bit 30 (compensation stopped) reads 1, and only then touches any lane register.
- R2: Each lane write changes only bits 15:8 (delay code) of the value read from that lane; all other bits are written back as read.
- R3: The new code is the old code plus the step, with the step an 8-bit two's-complement value, clamped to 0 when the sum is negative and to 255 when it exceeds 255.
- R4: Each lane write is followed at once by a read of the same lane address before the next lane is started.
- R5: Lanes are visited in ascending order 0 to N-1, lane i at address 0x0100 + i*0x0040.
- R6: After the last lane, the block writes the saved configuration value with bit 26 cleared and issues no further status reads.
- R7: A lane count of zero performs the freeze, the status polling and the release with no lane access.
- R8: done is high for exactly one cycle, the cycle after the release write is acknowledged, and busy is high from the cycle after start until then.
- R9: A start pulse while busy is ignored: it does not change the step or lane count in use and starts no second pass.
- R10: While a request is not acknowledged, request, address, direction and write data stay unchanged; no request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| lanes_i | input | LANE_CNT_W (4) | Number of lanes to adjust |
| step_i | input | STEP_W (8) | Signed delay step |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W (16) | Register address |
| bus_wdata_o | output | DATA_W (32) | Write data |
| bus_ack_i | input | 1 | One-cycle acknowledge |
| bus_rdata_i | input | DATA_W (32) | Read data, valid with acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first request appears the cycle after start is sampled, and each following request is presented the cycle after the previous acknowledge, so the whole pass is a chain of bus transactions whose timing the responder sets. The bench's register model varies the acknowledge latency, logs every acknowledged transaction and compares the log with the sequence expected from R1 to R7. The done pulse is counted every cycle, and results are read from the model only after done plus a settling margin, so extra transactions or a second done after the pass are caught as well.

// File: rtl/lda_pkg.sv
package lda_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CFG_RD,
      ST_CFG_WR,
      ST_POLL,
      ST_LANE_RD,
      ST_LANE_WR,
      ST_LANE_CHK,
      ST_RELEASE
   } lda_state_e;
endpackage

// File: rtl/lda_code_sat.sv
module lda_code_sat #(
   parameter int CODE_W = 8,
   parameter int STEP_W = 8
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [CODE_W-1:0] code_o
);
   localparam int SUM_W = ((CODE_W > STEP_W) ? CODE_W : STEP_W) + 2;
   localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((1 << CODE_W) - 1);

   logic signed [SUM_W-1:0] base_s, step_s, sum_s;

   always_comb begin
      base_s = SUM_W'(code_i);
      step_s = {{(SUM_W-STEP_W){step_i[STEP_W-1]}}, step_i};
      sum_s  = base_s + step_s;
      if (sum_s < 0)
         code_o = '0;
      else if (sum_s > CODE_MAX)
         code_o = '1;
      else
         code_o = sum_s[CODE_W-1:0];
   end
endmodule

// File: rtl/lda_addr_gen.sv
module lda_addr_gen #(
   parameter int ADDR_W      = 16,
   parameter int IDX_W       = 4,
   parameter int LANE_BASE   = 'h0100,
   parameter int LANE_STRIDE = 'h0040
) (
   input  logic [IDX_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int  STRIDE_LOG = $clog2(LANE_STRIDE);
   localparam bit  STRIDE_P2  = ((1 << STRIDE_LOG) == LANE_STRIDE);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(LANE_BASE);

   generate
      if (STRIDE_P2) begin : g_shift
         assign addr_o = BASE_A + (ADDR_W'(idx_i) << STRIDE_LOG);
      end else begin : g_mult
         assign addr_o = BASE_A + ADDR_W'(idx_i) * ADDR_W'(LANE_STRIDE);
      end
   endgenerate
endmodule

// File: rtl/lane_delay_adjust.sv
module lane_delay_adjust #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int LANE_CNT_W  = 4,
   parameter int STEP_W      = 8,
   parameter int CODE_LSB    = 8,
   parameter int CODE_W      = 8,
   parameter int CFG_ADDR    = 'h0008,
   parameter int STAT_ADDR   = 'h0010,
   parameter int LANE_BASE   = 'h0100,
   parameter int LANE_STRIDE = 'h0040,
   parameter int INHIBIT_BIT = 26,
   parameter int STOPPED_BIT = 30
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [LANE_CNT_W-1:0] lanes_i,
   input  logic [STEP_W-1:0]     step_i,
   output logic                  bus_req_o,
   output logic                  bus_we_o,
   output logic [ADDR_W-1:0]     bus_addr_o,
   output logic [DATA_W-1:0]     bus_wdata_o,
   input  logic                  bus_ack_i,
   input  logic [DATA_W-1:0]     bus_rdata_i,
   output logic                  busy_o,
   output logic                  done_o
);
   import lda_pkg::*;

   localparam logic [DATA_W-1:0] INH_MASK   = DATA_W'(1) << INHIBIT_BIT;
   localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'((1 << CODE_W) - 1) << CODE_LSB;

   generate
      if (CODE_LSB + CODE_W > DATA_W) begin : g_bad_field
         $error("delay code field exceeds register width");
      end
      if (INHIBIT_BIT >= DATA_W || STOPPED_BIT >= DATA_W) begin : g_bad_bit
         $error("control bit position exceeds register width");
      end
      if (LANE_STRIDE < 1) begin : g_bad_stride
         $error("lane stride must be positive");
      end
   endgenerate

   lda_state_e            state_q;
   logic [LANE_CNT_W-1:0] lanes_q;
   logic [LANE_CNT_W-1:0] idx_q;
   logic [STEP_W-1:0]     step_q;
   logic [DATA_W-1:0]     cfg_q;
   logic [DATA_W-1:0]     lane_q;
   logic                  done_q;
   logic [CODE_W-1:0]     new_code;
   logic [ADDR_W-1:0]     lane_addr;
   logic [DATA_W-1:0]     lane_merged;

   lda_code_sat #(.CODE_W(CODE_W), .STEP_W(STEP_W)) i_sat (
      .code_i (lane_q[CODE_LSB +: CODE_W]),
      .step_i (step_q),
      .code_o (new_code)
   );

   lda_addr_gen #(
      .ADDR_W(ADDR_W), .IDX_W(LANE_CNT_W),
      .LANE_BASE(LANE_BASE), .LANE_STRIDE(LANE_STRIDE)
   ) i_addr (
      .idx_i  (idx_q),
      .addr_o (lane_addr)
   );

   assign lane_merged = (lane_q & ~FIELD_MASK) | (DATA_W'(new_code) << CODE_LSB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lanes_q <= '0;
         idx_q   <= '0;
         step_q  <= '0;
         cfg_q   <= '0;
         lane_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               lanes_q <= lanes_i;
               step_q  <= step_i;
               idx_q   <= '0;
               state_q <= ST_CFG_RD;
            end
            ST_CFG_RD: if (bus_ack_i) begin
               cfg_q   <= bus_rdata_i;
               state_q <= ST_CFG_WR;
            end
            ST_CFG_WR: if (bus_ack_i) state_q <= ST_POLL;
            ST_POLL: if (bus_ack_i && bus_rdata_i[STOPPED_BIT])
               state_q <= (lanes_q == '0) ? ST_RELEASE : ST_LANE_RD;
            ST_LANE_RD: if (bus_ack_i) begin
               lane_q  <= bus_rdata_i;
               state_q <= ST_LANE_WR;
            end
            ST_LANE_WR: if (bus_ack_i) state_q <= ST_LANE_CHK;
            ST_LANE_CHK: if (bus_ack_i) begin
               if (idx_q == lanes_q - 1'b1) begin
                  state_q <= ST_RELEASE;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_LANE_RD;
               end
            end
            ST_RELEASE: if (bus_ack_i) begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_we_o    = 1'b0;
      bus_addr_o  = '0;
      bus_wdata_o = '0;
      case (state_q)
         ST_CFG_RD:   bus_addr_o = ADDR_W'(CFG_ADDR);
         ST_CFG_WR: begin
            bus_we_o    = 1'b1;
            bus_addr_o  = ADDR_W'(CFG_ADDR);
            bus_wdata_o = cfg_q | INH_MASK;
         end
         ST_POLL:     bus_addr_o = ADDR_W'(STAT_ADDR);
         ST_LANE_RD,
         ST_LANE_CHK: bus_addr_o = lane_addr;
         ST_LANE_WR: begin
            bus_we_o    = 1'b1;
            bus_addr_o  = lane_addr;
            bus_wdata_o = lane_merged;
         end
         ST_RELEASE: begin
            bus_we_o    = 1'b1;
            bus_addr_o  = ADDR_W'(CFG_ADDR);
            bus_wdata_o = cfg_q & ~INH_MASK;
         end
         default: ;
      endcase
   end

   assign bus_req_o = (state_q != ST_IDLE);
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;
endmodule

// File: rtl/lda_checker.sv
module lda_checker #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int STAT_ADDR   = 'h0010,
   parameter int LANE_BASE   = 'h0100,
   parameter int STOPPED_BIT = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req_o,
   input logic              bus_we_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [DATA_W-1:0] bus_wdata_o,
   input logic              bus_ack_i,
   input logic [DATA_W-1:0] bus_rdata_i,
   input logic              busy_o,
   input logic              done_o
);
   logic stop_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stop_seen <= 1'b0;
      else if (!busy_o)
         stop_seen <= 1'b0;
      else if (bus_req_o && bus_ack_i && !bus_we_o &&
               bus_addr_o == ADDR_W'(STAT_ADDR) && bus_rdata_i[STOPPED_BIT])
         stop_seen <= 1'b1;
   end

   p_lane_after_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_addr_o >= ADDR_W'(LANE_BASE)) |-> stop_seen);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                     $stable(bus_we_o) && $stable(bus_wdata_o)));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !bus_req_o);
endmodule

bind lane_delay_adjust lda_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
   .LANE_BASE(LANE_BASE), .STOPPED_BIT(STOPPED_BIT)
) i_lda_checker (
   .clk(clk), .rst_n(rst_n), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
   .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i),
   .bus_rdata_i(bus_rdata_i), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_lane_delay_adjust.sv
`timescale 1ns/1ps
module test_lane_delay_adjust;
   localparam logic [15:0] A_CFG   = 16'h0008;
   localparam logic [15:0] A_STAT  = 16'h0010;
   localparam int          BASE    = 'h0100;
   localparam int          STRIDE  = 'h0040;
   localparam logic [31:0] CFG_INIT = 32'h0A5C_3210;
   localparam logic [31:0] INH     = 32'h0400_0000;
   localparam int          STOP_AFTER = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  lanes = '0;
   logic [7:0]  step = '0;
   logic        req, we, ack, busy, done;
   logic [15:0] addr;
   logic [31:0] wdata, rdata;

   int vectors = 0;
   int errors = 0;

   // model control, driven by the stimulus only
   logic        load_req = 1'b0;
   logic [31:0] load_val [16];

   // register model state, driven by the model only
   logic [31:0] cfg_reg;
   logic [31:0] lane_reg [16];
   int          polls;
   int          lat;
   int          wcnt;
   int          done_cnt;
   int          log_n;
   logic        log_we   [96];
   logic [15:0] log_addr [96];
   logic [31:0] log_data [96];

   always #2.5 clk = ~clk;

   lane_delay_adjust i_lane_delay_adjust (
      .clk(clk), .rst_n(rst_n), .start_i(start), .lanes_i(lanes), .step_i(step),
      .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
      .bus_ack_i(ack), .bus_rdata_i(rdata), .busy_o(busy), .done_o(done)
   );

   always @(posedge clk) begin
      if (load_req || !rst_n) begin
         ack <= 1'b0; rdata <= '0; wcnt <= 0; lat <= 0; polls <= 0;
         log_n <= 0; done_cnt <= 0; cfg_reg <= CFG_INIT;
         for (int i = 0; i < 16; i++) lane_reg[i] <= load_val[i];
      end else begin
         if (done) done_cnt <= done_cnt + 1;
         if (ack) begin
            ack <= 1'b0;
         end else if (req) begin
            if (wcnt < lat) begin
               wcnt <= wcnt + 1;
            end else begin
               wcnt <= 0;
               lat  <= (lat == 0) ? 2 : 0;
               ack  <= 1'b1;
               if (log_n < 96) begin
                  log_we[log_n]   <= we;
                  log_addr[log_n] <= addr;
                  log_data[log_n] <= we ? wdata : 32'h0;
                  log_n <= log_n + 1;
               end
               if (we) begin
                  if (addr == A_CFG) begin
                     cfg_reg <= wdata;
                     polls <= 0;
                  end else if (addr >= 16'(BASE))
                     lane_reg[(int'(addr) - BASE) / STRIDE] <= wdata;
               end else begin
                  if (addr == A_CFG) rdata <= cfg_reg;
                  else if (addr == A_STAT) begin
                     rdata <= (cfg_reg[26] && polls >= STOP_AFTER) ? 32'h4000_0000 : 32'h0;
                     polls <= polls + 1;
                  end else if (addr >= 16'(BASE))
                     rdata <= lane_reg[(int'(addr) - BASE) / STRIDE];
                  else rdata <= '0;
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_code(input logic [7:0] old, input logic [7:0] st);
      int s;
      s = int'(old) + int'($signed(st));
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      return 8'(s);
   endfunction

   task automatic load(input logic [31:0] v [16]);
      @(negedge clk);
      for (int i = 0; i < 16; i++) load_val[i] = v[i];
      load_req = 1'b1;
      @(negedge clk);
      load_req = 1'b0;
   endtask

   task automatic run(input logic [3:0] n, input logic [7:0] s, input bit extra_start);
      @(negedge clk);
      start = 1'b1; lanes = n; step = s;
      @(negedge clk);
      start = 1'b0;
      if (extra_start) begin
         repeat (6) @(negedge clk);
         start = 1'b1; lanes = 4'd2; step = 8'h64;
         @(negedge clk);
         start = 1'b0;
      end
      for (int t = 0; t < 3000 && done_cnt == 0; t++) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   task automatic check_pass(input logic [3:0] n, input logic [7:0] s, input logic [31:0] v [16]);
      int p;
      int k;
      logic [15:0] la;
      logic [31:0] exp_w;
      chk(done_cnt == 1, "R8 done pulse count", 32'(done_cnt), 32'd1);
      chk(!log_we[0] && log_addr[0] == A_CFG, "R1 config read first", 32'(log_addr[0]), 32'(A_CFG));
      chk(log_we[1] && log_addr[1] == A_CFG && log_data[1] == (CFG_INIT | INH),
          "R1 inhibit write", log_data[1], CFG_INIT | INH);
      p = 2; k = 0;
      while (p < log_n && !log_we[p] && log_addr[p] == A_STAT) begin p++; k++; end
      chk(k == STOP_AFTER + 1, "R1 status polls", 32'(k), 32'(STOP_AFTER + 1));
      for (int i = 0; i < int'(n); i++) begin
         la = 16'(BASE + i * STRIDE);
         exp_w = (v[i] & 32'hFFFF_00FF) | (32'(exp_code(v[i][15:8], s)) << 8);
         chk(!log_we[p] && log_addr[p] == la, "R5 lane read order", 32'(log_addr[p]), 32'(la));
         chk(log_we[p+1] && log_addr[p+1] == la && log_data[p+1] == exp_w,
             "R2 R3 lane write data", log_data[p+1], exp_w);
         chk(!log_we[p+2] && log_addr[p+2] == la, "R4 dummy read", 32'(log_addr[p+2]), 32'(la));
         chk(lane_reg[i] == exp_w, "R3 lane result", lane_reg[i], exp_w);
         p += 3;
      end
      chk(log_we[p] && log_addr[p] == A_CFG && log_data[p] == CFG_INIT,
          "R6 release write", log_data[p], CFG_INIT);
      chk(log_n == p + 1, "R6 no trailing access", 32'(log_n), 32'(p + 1));
      chk(!busy && !req, "R8 idle after done", {30'd0, busy, req}, 32'd0);
      for (int i = int'(n); i < 16; i++)
         if (lane_reg[i] != v[i]) chk(1'b0, "R5 untouched lane", lane_reg[i], v[i]);
   endtask

   task automatic t_basic();
      logic [31:0] v [16];
      for (int i = 0; i < 16; i++) v[i] = 32'hC3A5_0000 | 32'(i * 17) | (32'(8'h40 + i) << 8);
      v[0] = 32'h1234_10AB; v[1] = 32'hFFFF_02FF; v[2] = 32'h0000_0000; v[3] = 32'hA5A5_FF5A;
      load(v);
      run(4'd4, 8'hFC, 1'b0);
      check_pass(4'd4, 8'hFC, v);
   endtask

   task automatic t_sat_high();
      logic [31:0] v [16];
      for (int i = 0; i < 16; i++) v[i] = 32'h0F0F_0000 | (32'(8'h80 + i * 8) << 8) | 32'(i);
      v[0] = 32'h7777_F077;
      load(v);
      run(4'd6, 8'h7F, 1'b0);
      check_pass(4'd6, 8'h7F, v);
      chk(lane_reg[0][15:8] == 8'hFF, "R3 clamp high", 32'(lane_reg[0][15:8]), 32'hFF);
   endtask

   task automatic t_sat_low();
      logic [31:0] v [16];
      for (int i = 0; i < 16; i++) v[i] = 32'h5555_0000 | (32'(8'h70 + i * 3) << 8);
      v[1] = 32'h0000_8000;
      load(v);
      run(4'd15, 8'h80, 1'b0);
      check_pass(4'd15, 8'h80, v);
      chk(lane_reg[0][15:8] == 8'h00, "R3 clamp low", 32'(lane_reg[0][15:8]), 32'h0);
   endtask

   task automatic t_zero_lanes();
      logic [31:0] v [16];
      for (int i = 0; i < 16; i++) v[i] = 32'h1111_2200 + 32'(i);
      load(v);
      run(4'd0, 8'hFC, 1'b0);
      check_pass(4'd0, 8'hFC, v);
      chk(log_n == STOP_AFTER + 4, "R7 zero-lane transaction count", 32'(log_n), 32'(STOP_AFTER + 4));
   endtask

   task automatic t_start_busy();
      logic [31:0] v [16];
      for (int i = 0; i < 16; i++) v[i] = 32'h2468_0000 | (32'(8'h20 + i) << 8);
      load(v);
      run(4'd3, 8'h05, 1'b1);
      check_pass(4'd3, 8'h05, v);
      chk(lane_reg[2] == ((v[2] & 32'hFFFF_00FF) | (32'(exp_code(v[2][15:8], 8'h05)) << 8)),
          "R9 start while busy ignored", lane_reg[2], v[2]);
   endtask

   initial begin
      #500_000;
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) load_val[i] = '0;
      repeat (3) @(negedge clk);
      chk(!req && !busy && !done, "R8 R10 reset state", {29'd0, req, busy, done}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_basic();
      t_sat_high();
      t_sat_low();
      t_zero_lanes();
      t_start_busy();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule